// File: doc/BRIEF.md
# Weight-Stationary Systolic Matrix Multiplier

This block multiplies a stream of activation vectors by a square weight matrix held inside an N×N grid of multiply-accumulate cells. The weights are shifted into the grid first and then stay in their cells. Each activation vector then enters at the left edge. Every element travels rightward through its row, one cell per clock. Partial sums start at zero at the top edge and move down the columns, and each cell adds its own product on the way.

A skew stage delays lane r by r clocks, so that each cell sees the matching activation and partial sum on the same edge. A de-skew stage at the bottom delays column c by N−1−c clocks, so all column sums leave together. They then reach one accumulator per column. Vectors can be grouped, and the block emits one output row per group, equal to the sum of the group's products. An optional ReLU clamp can be applied to that row. A busy flag covers the time during which vectors are still inside the pipeline.

Top module: `ws_matmul_top`

## Requirements
- R1: While reset is held, and on the first cycle after it is released, out_valid and busy are 0.
- R2: Loading takes N cycles with wld_valid high. The row given on the k-th load cycle (k counted from 0) ends up as weight row N−1−k. Weight column c is carried in bits [8c+7:8c] of wld_row, as signed two's-complement values. Loads happen only while busy and act_valid are both 0.
- R3: Activation lane r is carried in bits [8r+7:8r] of act_vec, as a signed 8-bit value. Output column c, in bits [32c+31:32c] of out_row, is the 32-bit two's-complement value of the sum over r of act[r]·W[r][c].
- R4: A vector accepted with act_last=1 on a clock edge has its row registered 2N edges later, counting the accepting edge as the first. All N columns are presented together with a single one-cycle out_valid pulse.
- R5: A new vector can be accepted on every cycle with no gaps. Results come out in the order the vectors were accepted.
- R6: A vector accepted with act_last=0 adds its column sums into the accumulators and produces no output. The next vector accepted with act_last=1 produces the total of the whole group, and the accumulators then restart from zero.
- R7: With relu_on=1, any negative column result is output as 0. With relu_on=0, results pass through unchanged.
- R8: busy rises on the edge that accepts a vector after an idle period. It stays 1 until the edge that retires the last vector still in flight, and it is 0 after that.
- R9: Loaded weights are used for every later vector until a new load replaces them. After a reload, the new weights apply to all vectors that follow.
- R10: out_valid is never asserted in a cycle that does not correspond to a vector accepted with act_last=1.
- R11: When act_valid=0, the values on act_vec and act_last have no effect on any result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wld_valid | input | 1 | Shifts one weight row in from the top |
| wld_row | input | N*8 | Weight row, one signed byte per column |
| act_valid | input | 1 | Activation vector present |
| act_last | input | 1 | Closes the current accumulation group |
| act_vec | input | N*8 | Activation vector, one signed byte per lane |
| relu_on | input | 1 | Enables the clamp of negative results |
| out_valid | output | 1 | Output row pulse |
| out_row | output | N*32 | Output row, one signed 32-bit word per column |
| busy | output | 1 | Vectors are in flight |

## Verification
The assertions rely on two input rules. Weight loads arrive only while the block is idle and no vector is being offered, and relu_on changes only when no result is about to be registered. The bench keeps to both rules: every weight load, and every change of the ReLU mode, takes place only after the pipeline has fully drained. The in-flight bound and the busy/result relations then follow from the design's own pipeline depth.

// File: rtl/ws_pkg.sv
package ws_pkg;
  localparam int OPW  = 8;
  localparam int SUMW = 32;

  typedef logic signed [OPW-1:0]  op_t;
  typedef logic signed [SUMW-1:0] sum_t;

  // One cell step: add the product of activation and held weight to the partial sum
  function automatic sum_t mac_step(sum_t ps, op_t a, op_t w);
    sum_t prod;
    prod = sum_t'(a) * sum_t'(w);
    return ps + prod;
  endfunction

  // Output clamp: negative values become zero when enabled
  function automatic sum_t relu_clip(sum_t v, logic en);
    return (en && v[SUMW-1]) ? '0 : v;
  endfunction
endpackage

// File: rtl/ws_delay.sv
module ws_delay #(
  parameter int W = 8,
  parameter int D = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stg [D];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < D; i++) stg[i] <= '0;
    end else begin
      stg[0] <= din;
      for (int i = 1; i < D; i++) stg[i] <= stg[i-1];
    end
  end

  assign dout = stg[D-1];
endmodule

// File: rtl/ws_skew.sv
module ws_skew #(
  parameter int N   = 4,
  parameter int W   = 8,
  parameter bit REV = 1'b0
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [N*W-1:0] din,
  output logic [N*W-1:0] dout
);
  for (genvar i = 0; i < N; i++) begin : g_lane
    localparam int DLY = REV ? (N - 1 - i) : i;
    if (DLY == 0) begin : g_thru
      assign dout[i*W +: W] = din[i*W +: W];
    end else begin : g_dly
      ws_delay #(.W(W), .D(DLY)) u_dly (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (din[i*W +: W]),
        .dout (dout[i*W +: W])
      );
    end
  end
endmodule

// File: rtl/ws_cell.sv
module ws_cell
  import ws_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic w_shift,
  input  op_t  w_in,
  output op_t  w_out,
  input  op_t  a_in,
  output op_t  a_out,
  input  sum_t ps_in,
  output sum_t ps_out
);
  op_t  w_q;
  op_t  a_q;
  sum_t ps_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      w_q  <= '0;
      a_q  <= '0;
      ps_q <= '0;
    end else begin
      if (w_shift) w_q <= w_in;
      a_q  <= a_in;
      ps_q <= mac_step(ps_in, a_in, w_q);
    end
  end

  assign w_out  = w_q;
  assign a_out  = a_q;
  assign ps_out = ps_q;
endmodule

// File: rtl/ws_grid.sv
module ws_grid
  import ws_pkg::*;
#(
  parameter int N = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wld_valid,
  input  logic [N*OPW-1:0]  wld_row,
  input  logic [N*OPW-1:0]  a_left,
  output logic [N*SUMW-1:0] ps_bot
);
  op_t  a_h [N][N+1];
  op_t  w_v [N+1][N];
  sum_t p_v [N+1][N];

  for (genvar r = 0; r < N; r++) begin : g_left
    assign a_h[r][0] = op_t'(a_left[r*OPW +: OPW]);
  end

  for (genvar c = 0; c < N; c++) begin : g_edge
    assign w_v[0][c] = op_t'(wld_row[c*OPW +: OPW]);
    assign p_v[0][c] = '0;
    assign ps_bot[c*SUMW +: SUMW] = p_v[N][c];
  end

  for (genvar r = 0; r < N; r++) begin : g_row
    for (genvar c = 0; c < N; c++) begin : g_col
      ws_cell u_cell (
        .clk   (clk),
        .rst_n (rst_n),
        .w_shift(wld_valid),
        .w_in  (w_v[r][c]),
        .w_out (w_v[r+1][c]),
        .a_in  (a_h[r][c]),
        .a_out (a_h[r][c+1]),
        .ps_in (p_v[r][c]),
        .ps_out(p_v[r+1][c])
      );
    end
  end
endmodule

// File: rtl/ws_accum.sv
module ws_accum
  import ws_pkg::*;
#(
  parameter int N = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tag_valid,
  input  logic              tag_last,
  input  logic              relu_on,
  input  logic [N*SUMW-1:0] col_in,
  output logic              out_valid,
  output logic [N*SUMW-1:0] out_row
);
  logic [N-1:0] neg_col;
  logic         vld_q;

  for (genvar c = 0; c < N; c++) begin : g_col
    sum_t acc_q;
    sum_t res_q;
    sum_t total;

    assign total = acc_q + sum_t'(col_in[c*SUMW +: SUMW]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        acc_q <= '0;
        res_q <= '0;
      end else if (tag_valid) begin
        if (tag_last) begin
          acc_q <= '0;
          res_q <= relu_clip(total, relu_on);
        end else begin
          acc_q <= total;
        end
      end
    end

    assign out_row[c*SUMW +: SUMW] = res_q;
    assign neg_col[c] = res_q[SUMW-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= tag_valid & tag_last;
  end

  assign out_valid = vld_q;

  // R7
  relu_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(relu_on)) |-> (neg_col == '0));
endmodule

// File: rtl/ws_matmul_top.sv
module ws_matmul_top
  import ws_pkg::*;
#(
  parameter int N = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wld_valid,
  input  logic [N*OPW-1:0]  wld_row,
  input  logic              act_valid,
  input  logic              act_last,
  input  logic [N*OPW-1:0]  act_vec,
  input  logic              relu_on,
  output logic              out_valid,
  output logic [N*SUMW-1:0] out_row,
  output logic              busy
);
  localparam int TAGD = 2 * N - 1;
  localparam int CNTW = $clog2(2 * N) + 1;

  logic [N*OPW-1:0]  act_gated;
  logic [N*OPW-1:0]  a_left;
  logic [N*SUMW-1:0] ps_bot;
  logic [N*SUMW-1:0] col_aligned;
  logic [1:0]        tag_pipe;
  logic              tag_at_acc;
  logic              tag_last_at_acc;
  logic [CNTW-1:0]   inflight;

  assign act_gated = act_valid ? act_vec : '0;

  ws_skew #(.N(N), .W(OPW), .REV(1'b0)) u_skew (
    .clk(clk), .rst_n(rst_n), .din(act_gated), .dout(a_left)
  );

  ws_grid #(.N(N)) u_grid (
    .clk(clk), .rst_n(rst_n), .wld_valid(wld_valid), .wld_row(wld_row),
    .a_left(a_left), .ps_bot(ps_bot)
  );

  ws_skew #(.N(N), .W(SUMW), .REV(1'b1)) u_deskew (
    .clk(clk), .rst_n(rst_n), .din(ps_bot), .dout(col_aligned)
  );

  ws_delay #(.W(2), .D(TAGD)) u_tag (
    .clk(clk), .rst_n(rst_n),
    .din({act_valid, act_valid & act_last}), .dout(tag_pipe)
  );

  assign tag_at_acc      = tag_pipe[1];
  assign tag_last_at_acc = tag_pipe[0];

  ws_accum #(.N(N)) u_accum (
    .clk(clk), .rst_n(rst_n), .tag_valid(tag_at_acc), .tag_last(tag_last_at_acc),
    .relu_on(relu_on), .col_in(col_aligned), .out_valid(out_valid), .out_row(out_row)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inflight <= '0;
    end else begin
      case ({act_valid, tag_at_acc})
        2'b10:   inflight <= inflight + CNTW'(1);
        2'b01:   inflight <= inflight - CNTW'(1);
        default: inflight <= inflight;
      endcase
    end
  end

  assign busy = (inflight != '0);

  // R2
  load_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wld_valid |-> (!busy && !act_valid));

  // R8
  out_within_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(busy));

  // R8
  busy_drop_on_retire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(tag_at_acc));

  // R5
  inflight_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inflight <= CNTW'(TAGD));
endmodule

// File: tb/ws_matmul_top_test.sv
module ws_matmul_top_test;
  localparam int N   = 4;
  localparam int LAT = 2 * N;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            wld_valid = 1'b0;
  logic [N*8-1:0]  wld_row = '0;
  logic            act_valid = 1'b0;
  logic            act_last = 1'b0;
  logic [N*8-1:0]  act_vec = '0;
  logic            relu_on = 1'b0;
  logic            out_valid;
  logic [N*32-1:0] out_row;
  logic            busy;

  always #5 clk = ~clk;

  ws_matmul_top #(.N(N)) uut (
    .clk(clk), .rst_n(rst_n), .wld_valid(wld_valid), .wld_row(wld_row),
    .act_valid(act_valid), .act_last(act_last), .act_vec(act_vec),
    .relu_on(relu_on), .out_valid(out_valid), .out_row(out_row), .busy(busy)
  );

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  int wt [N][N];
  int grp [N];
  int exp_val [512][N];
  int exp_cyc [512];
  string exp_tag [512];
  int wr_ptr = 0;
  int rd_ptr = 0;
  string cur_tag = "R3";
  int unsigned seed = 32'h1234_5678;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  function automatic int rnd8();
    seed = seed * 32'd1103515245 + 32'd12345;
    return int'((seed >> 16) & 32'hFF) - 128;
  endfunction

  // Output monitor: values (R3, R6, R7, R9), timing (R4), spurious rows (R10)
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (rd_ptr == wr_ptr) begin
        chk(1'b0, "R10 unexpected output row", 1, 0);
      end else begin
        for (int c = 0; c < N; c++) begin
          int got;
          got = $signed(out_row[c*32 +: 32]);
          chk(got == exp_val[rd_ptr][c], exp_tag[rd_ptr], got, exp_val[rd_ptr][c]);
        end
        chk(cyc == exp_cyc[rd_ptr], "R4 latency", cyc, exp_cyc[rd_ptr]);
        rd_ptr++;
      end
    end
  end

  always @(posedge clk) begin
    if (cyc == 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog R8 run did not finish actual=%0d expected=%0d", cyc, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic load_w();
    for (int k = 0; k < N; k++) begin
      @(negedge clk);
      wld_valid = 1'b1;
      for (int c = 0; c < N; c++) wld_row[c*8 +: 8] = wt[N-1-k][c][7:0];
    end
    @(negedge clk);
    wld_valid = 1'b0;
    wld_row = '1;
  endtask

  task automatic send(input int a [N], input bit last);
    @(negedge clk);
    act_valid = 1'b1;
    act_last = last;
    for (int r = 0; r < N; r++) act_vec[r*8 +: 8] = a[r][7:0];
    for (int c = 0; c < N; c++) begin
      int s;
      s = 0;
      for (int r = 0; r < N; r++) s += a[r] * wt[r][c];
      grp[c] += s;
    end
    if (last) begin
      for (int c = 0; c < N; c++) begin
        exp_val[wr_ptr][c] = (relu_on && grp[c] < 0) ? 0 : grp[c];
        grp[c] = 0;
      end
      exp_cyc[wr_ptr] = cyc + LAT;
      exp_tag[wr_ptr] = cur_tag;
      wr_ptr++;
    end
  endtask

  // R11: junk on the data and last inputs while act_valid is low
  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      act_valid = 1'b0;
      act_last = 1'b0;
      act_vec = {N{8'h80 ^ 8'(i * 37)}};
    end
  endtask

  task automatic drain();
    idle(1);
    while (rd_ptr != wr_ptr) @(negedge clk);
    @(negedge clk);
    #1;
    chk(busy == 1'b0, "R8 busy low after drain", int'(busy), 0);
  endtask

  task automatic send_rand(input int count, input bit last);
    for (int i = 0; i < count; i++) begin
      int v [N];
      for (int r = 0; r < N; r++) v[r] = rnd8();
      send(v, last);
    end
  endtask

  initial begin
    for (int c = 0; c < N; c++) grp[c] = 0;
    repeat (3) @(posedge clk);
    #1;
    chk(out_valid == 1'b0, "R1 out_valid in reset", int'(out_valid), 0);
    chk(busy == 1'b0, "R1 busy in reset", int'(busy), 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0, "R1 out_valid after reset", int'(out_valid), 0);
    chk(busy == 1'b0, "R1 busy after reset", int'(busy), 0);

    // R2, R3, R5: asymmetric weights, back-to-back random vectors
    for (int r = 0; r < N; r++)
      for (int c = 0; c < N; c++) wt[r][c] = ((r * 7 + c * 3 + 1) % 15) - 7;
    load_w();
    cur_tag = "R3/R5 random stream";
    begin
      int v [N];
      for (int r = 0; r < N; r++) v[r] = rnd8();
      send(v, 1'b1);
      @(posedge clk);
      #1;
      chk(busy == 1'b1, "R8 busy after first vector", int'(busy), 1);
    end
    send_rand(30, 1'b1);
    drain();

    // R2: one-hot lane sweep exposes the row and column placement
    cur_tag = "R2 one-hot lane sweep";
    for (int r = 0; r < N; r++) begin
      for (int k = 0; k < 5; k++) begin
        int v [N];
        int vals [5];
        vals = '{-128, -1, 1, 2, 127};
        for (int q = 0; q < N; q++) v[q] = 0;
        v[r] = vals[k];
        send(v, 1'b1);
      end
    end
    drain();

    // R3 and R9: reload with extreme weights
    for (int r = 0; r < N; r++)
      for (int c = 0; c < N; c++) wt[r][c] = ((r + c) % 2 == 1) ? 127 : -128;
    load_w();
    cur_tag = "R3/R9 extreme operands";
    for (int p = 0; p < 4; p++) begin
      int v [N];
      for (int r = 0; r < N; r++)
        v[r] = (p == 0) ? -128 : (p == 1) ? 127 : (p == 2) ? ((r % 2 == 1) ? 127 : -128) : ((r % 2 == 1) ? -128 : 127);
      send(v, 1'b1);
    end
    send_rand(10, 1'b1);
    drain();

    // R6, R10, R11: groups of varying size with bubbles carrying junk
    for (int r = 0; r < N; r++)
      for (int c = 0; c < N; c++) wt[r][c] = c - 2 * r;
    load_w();
    cur_tag = "R6/R10/R11 grouped with bubbles";
    for (int g = 0; g < 8; g++) begin
      int sz;
      sz = g % 3 + 1;
      for (int i = 0; i < sz; i++) begin
        int v [N];
        for (int r = 0; r < N; r++) v[r] = rnd8();
        send(v, i == sz - 1);
        if (g % 2 == 1) idle(i + 1);
      end
    end
    drain();

    // R7: clamp enabled, then disabled again
    relu_on = 1'b1;
    cur_tag = "R7 relu enabled";
    send_rand(20, 1'b1);
    drain();
    relu_on = 1'b0;
    cur_tag = "R7 relu disabled";
    send_rand(10, 1'b1);
    drain();

    chk(rd_ptr == wr_ptr, "R10 row count", rd_ptr, wr_ptr);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule